// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block stores the per-line interrupt state of a small interrupt controller. It covers 64 input lines and a single processor target. For each line it keeps an enable bit, a pending bit, an active bit, an 8-bit priority, an 8-bit target byte and a trigger-type bit. Pending state is captured from the input lines. A line set to edge mode latches pending on a rising edge. A line set to level mode shows pending while its input is high, or while software has set it pending.

Software reaches the bank through a 32-bit register port with word addresses. A read returns data one cycle after it is requested. The enable, pending and active bits each have a pair of windows: one sets bits and the other clears them. A 1 in the written word acts on the matching line and a 0 leaves that line alone. Either window of a pair reads back the current state.

A scan machine feeds the CPU interface. In state ST_SCAN it visits one line per clock and keeps the best eligible line seen so far. After the last line it moves to ST_COMMIT. ST_COMMIT publishes the winner and the priority of the winner, then returns to ST_SCAN at line 0. The published result is shown to the CPU interface only while the global enable is set.

Top module: `irqd_distributor`

## Requirements
- R1: After reset, every enable, pending, active, priority, target and trigger bit is 0, the global enable is 0, `irq_valid` is 0 and `bus_rdata` is 0.
- R2: Word 0x000 is the control word. Bit 0 is the global enable and reads back. While it is 0, `irq_valid` is 0 in the cycle after the write that cleared it.
- R3: Word 0x001 is read-only. It reads {CPU count - 1 in bits [7:5], line count / 32 - 1 in bits [4:0]}, which is 0x00000001 by default. Writes to it are ignored.
- R4: Enable bits are set through words 0x040+k and cleared through words 0x060+k, where line i is word k = i/32, bit i%32. A 1 acts on the line and a 0 has no effect. Both windows read the enable bits.
- R5: Pending bits are set through 0x080+k and cleared through 0x0A0+k, with the same mapping and write-one rule. Both windows read the effective pending bits.
- R6: Active bits are set through 0x0C0+k and cleared through 0x0E0+k, with the same mapping and write-one rule. Both windows read the active bits.
- R7: The priority byte of line i sits in word 0x100 + i/4, bits [8*(i%4)+7 : 8*(i%4)]. The target byte sits in the same position at word 0x200 + i/4. Both read back as written.
- R8: Trigger words are 0x300 + i/16. Bit 2*(i%16)+1 set to 1 selects edge mode and 0 selects level mode. The other bit of each pair reads 0. Lines below 32 are fixed at level mode: writes to their fields are ignored and the fields read 0.
- R9: An edge-mode line becomes pending on a rising edge of its input and stays pending after the input falls, until it is cleared. A level-mode line reads pending while its input is high.
- R10: Writes to words for lines at or above the line count have no effect. Those words and all unmapped words read 0.
- R11: The published line is the enabled, pending, not-active line with the numerically lowest priority byte. A tie goes to the lowest line number. `irq_prio` carries the byte of the winner, and `irq_valid` is 0 when no line is eligible. The result follows a change within 2*(line count+1) cycles.
- R12: `irq_id` changes only in the cycle that follows ST_COMMIT. While the machine is in ST_SCAN the published outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_lines | input | 64 | Interrupt input lines |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is returned on the next cycle |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data; 0 when no read was requested |
| irq_valid | output | 1 | A published interrupt is presented |
| irq_id | output | 6 | Line number of the published interrupt |
| irq_prio | output | 8 | Priority byte of the published interrupt |

## Verification
The bench targets the write-one windows in both polarities and with all-zero data. A design that treated 0 as "clear" would lose enables and pending bits. It also writes to the word just above the last line and to trigger fields below line 32: a careless decode would alias those writes onto real lines or make low lines edge-triggered. The selection is tested with a priority tie, with an active line that would otherwise win, and with the global enable dropped while a line is eligible. A wrong compare would pick the higher line, report an acknowledged line, or keep signalling while disabled. A short pulse on an edge line must stay pending after the input falls. A level-only capture would lose it.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    typedef enum logic [0:0] {
        ST_SCAN   = 1'b0,
        ST_COMMIT = 1'b1
    } scan_state_e;

    localparam logic [9:0] W_CTRL    = 10'h000;
    localparam logic [9:0] W_TYPE    = 10'h001;
    localparam logic [9:0] W_SETEN   = 10'h040;
    localparam logic [9:0] W_CLREN   = 10'h060;
    localparam logic [9:0] W_SETPEND = 10'h080;
    localparam logic [9:0] W_CLRPEND = 10'h0A0;
    localparam logic [9:0] W_SETACT  = 10'h0C0;
    localparam logic [9:0] W_CLRACT  = 10'h0E0;
    localparam logic [9:0] W_PRIO    = 10'h100;
    localparam logic [9:0] W_TGT     = 10'h200;
    localparam logic [9:0] W_CFG     = 10'h300;

    localparam int FIRST_CFG_LINE = 32;

endpackage

// File: rtl/irqd_line_bank.sv
module irqd_line_bank #(
    parameter int NL = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] lines,
    input  logic [NL-1:0] en_set,
    input  logic [NL-1:0] en_clr,
    input  logic [NL-1:0] pend_set,
    input  logic [NL-1:0] pend_clr,
    input  logic [NL-1:0] act_set,
    input  logic [NL-1:0] act_clr,
    input  logic [NL-1:0] cfg_wr,
    input  logic [NL-1:0] cfg_val,
    output logic [NL-1:0] en_vec,
    output logic [NL-1:0] pend_vec,
    output logic [NL-1:0] act_vec,
    output logic [NL-1:0] edge_vec
);

    logic [NL-1:0] pend_q;
    logic [NL-1:0] prev_q;

    for (genvar g = 0; g < NL; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_vec[g]   <= 1'b0;
                act_vec[g]  <= 1'b0;
                edge_vec[g] <= 1'b0;
                pend_q[g]   <= 1'b0;
                prev_q[g]   <= 1'b0;
            end else begin
                prev_q[g] <= lines[g];
                if (en_set[g])      en_vec[g] <= 1'b1;
                else if (en_clr[g]) en_vec[g] <= 1'b0;
                if (act_set[g])      act_vec[g] <= 1'b1;
                else if (act_clr[g]) act_vec[g] <= 1'b0;
                if (cfg_wr[g])       edge_vec[g] <= cfg_val[g];
                if (pend_set[g] || (edge_vec[g] && lines[g] && !prev_q[g]))
                    pend_q[g] <= 1'b1;
                else if (pend_clr[g])
                    pend_q[g] <= 1'b0;
            end
        end
        assign pend_vec[g] = pend_q[g] | (~edge_vec[g] & lines[g]);
    end

endmodule

// File: rtl/irqd_byte_bank.sv
module irqd_byte_bank #(
    parameter int NL = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [7:0]      word_idx,
    input  logic [31:0]     wdata,
    output logic [NL*8-1:0] bytes_q
);

    localparam int WORDS = NL / 4;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bytes_q[w*32 +: 32] <= '0;
            else if (wr && word_idx == 8'(w))
                bytes_q[w*32 +: 32] <= wdata;
        end
    end

endmodule

// File: rtl/irqd_scan.sv
module irqd_scan
    import irqd_pkg::*;
#(
    parameter int NL = 64,
    localparam int IDW = $clog2(NL)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NL-1:0]   elig,
    input  logic [NL*8-1:0] prio_bytes,
    output logic            pub_valid,
    output logic [IDW-1:0]  pub_id,
    output logic [7:0]      pub_prio,
    output scan_state_e     state
);

    scan_state_e    state_nx;
    logic [IDW-1:0] idx;
    logic           best_found;
    logic [IDW-1:0] best_id;
    logic [7:0]     best_prio;
    logic [7:0]     cand_prio;
    logic           take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SCAN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SCAN:   if (idx == IDW'(NL - 1)) state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_SCAN;
        endcase
    end

    assign cand_prio = prio_bytes[{idx, 3'b000} +: 8];
    assign take      = elig[idx] && (!best_found || cand_prio < best_prio);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx        <= '0;
            best_found <= 1'b0;
            best_id    <= '0;
            best_prio  <= '0;
            pub_valid  <= 1'b0;
            pub_id     <= '0;
            pub_prio   <= '0;
        end else begin
            unique case (state)
                ST_SCAN: begin
                    if (take) begin
                        best_found <= 1'b1;
                        best_id    <= idx;
                        best_prio  <= cand_prio;
                    end
                    idx <= idx + 1'b1;
                end
                ST_COMMIT: begin
                    pub_valid  <= best_found;
                    pub_id     <= best_id;
                    pub_prio   <= best_prio;
                    best_found <= 1'b0;
                    idx        <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/irqd_distributor.sv
module irqd_distributor
    import irqd_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 1,
    localparam int IDW      = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [9:0]           bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 irq_valid,
    output logic [IDW-1:0]       irq_id,
    output logic [7:0]           irq_prio
);

    localparam int NL  = NUM_LINES;
    localparam int W32 = NL / 32;
    localparam int W16 = NL / 16;
    localparam int W4  = NL / 4;
    localparam logic [31:0] TYPE_VAL = {24'b0, 3'(NUM_CPUS - 1), 5'(W32 - 1)};

    logic                 ctrl_en;
    logic [NL-1:0]        en_vec, pend_vec, act_vec, edge_vec;
    logic [NL-1:0]        en_set, en_clr, pend_set, pend_clr, act_set, act_clr;
    logic [NL-1:0]        cfg_wr, cfg_val;
    logic [NL*8-1:0]      prio_bytes, tgt_bytes;
    logic [NL*2-1:0]      cfg_rd;
    logic                 pub_valid;
    scan_state_e          scan_state;
    logic [31:0]          rd_word;

    function automatic logic [NL-1:0] win_mask(input logic wr, input logic [9:0] a,
                                               input logic [9:0] base, input logic [31:0] d);
        logic [NL-1:0] m;
        m = '0;
        for (int k = 0; k < W32; k++)
            if (wr && a == base + 10'(k)) m[k*32 +: 32] = d;
        return m;
    endfunction

    function automatic logic [31:0] pick(input logic [NL*8-1:0] v, input logic [9:0] a,
                                         input logic [9:0] base, input int words);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < W4; k++)
            if (k < words && a == base + 10'(k)) r = v[k*32 +: 32];
        return r;
    endfunction

    always_comb begin
        en_set   = win_mask(bus_wr, bus_addr, W_SETEN,   bus_wdata);
        en_clr   = win_mask(bus_wr, bus_addr, W_CLREN,   bus_wdata);
        pend_set = win_mask(bus_wr, bus_addr, W_SETPEND, bus_wdata);
        pend_clr = win_mask(bus_wr, bus_addr, W_CLRPEND, bus_wdata);
        act_set  = win_mask(bus_wr, bus_addr, W_SETACT,  bus_wdata);
        act_clr  = win_mask(bus_wr, bus_addr, W_CLRACT,  bus_wdata);
    end

    always_comb begin
        cfg_wr  = '0;
        cfg_val = '0;
        for (int k = 0; k < W16; k++)
            for (int j = 0; j < 16; j++)
                if (bus_wr && bus_addr == W_CFG + 10'(k) && (k * 16 + j) >= FIRST_CFG_LINE) begin
                    cfg_wr[k*16 + j]  = 1'b1;
                    cfg_val[k*16 + j] = bus_wdata[2*j + 1];
                end
    end

    always_comb begin
        cfg_rd = '0;
        for (int i = 0; i < NL; i++) cfg_rd[2*i + 1] = edge_vec[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           ctrl_en <= 1'b0;
        else if (bus_wr && bus_addr == W_CTRL) ctrl_en <= bus_wdata[0];
    end

    irqd_line_bank #(.NL(NL)) u_lines (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines),
        .en_set(en_set), .en_clr(en_clr), .pend_set(pend_set), .pend_clr(pend_clr),
        .act_set(act_set), .act_clr(act_clr), .cfg_wr(cfg_wr), .cfg_val(cfg_val),
        .en_vec(en_vec), .pend_vec(pend_vec), .act_vec(act_vec), .edge_vec(edge_vec)
    );

    irqd_byte_bank #(.NL(NL)) u_prio (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr && bus_addr[9:8] == W_PRIO[9:8]),
        .word_idx(bus_addr[7:0]), .wdata(bus_wdata), .bytes_q(prio_bytes)
    );

    irqd_byte_bank #(.NL(NL)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr && bus_addr[9:8] == W_TGT[9:8]),
        .word_idx(bus_addr[7:0]), .wdata(bus_wdata), .bytes_q(tgt_bytes)
    );

    irqd_scan #(.NL(NL)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .elig(en_vec & pend_vec & ~act_vec), .prio_bytes(prio_bytes),
        .pub_valid(pub_valid), .pub_id(irq_id), .pub_prio(irq_prio), .state(scan_state)
    );

    assign irq_valid = pub_valid & ctrl_en;

    always_comb begin
        rd_word = '0;
        if (bus_addr == W_CTRL) rd_word = {31'b0, ctrl_en};
        if (bus_addr == W_TYPE) rd_word = TYPE_VAL;
        rd_word = rd_word
            | pick({{(NL*7){1'b0}}, en_vec},   bus_addr, W_SETEN,   W32)
            | pick({{(NL*7){1'b0}}, en_vec},   bus_addr, W_CLREN,   W32)
            | pick({{(NL*7){1'b0}}, pend_vec}, bus_addr, W_SETPEND, W32)
            | pick({{(NL*7){1'b0}}, pend_vec}, bus_addr, W_CLRPEND, W32)
            | pick({{(NL*7){1'b0}}, act_vec},  bus_addr, W_SETACT,  W32)
            | pick({{(NL*7){1'b0}}, act_vec},  bus_addr, W_CLRACT,  W32)
            | pick(prio_bytes,                 bus_addr, W_PRIO,    W4)
            | pick(tgt_bytes,                  bus_addr, W_TGT,     W4)
            | pick({{(NL*6){1'b0}}, cfg_rd},   bus_addr, W_CFG,     W16);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= bus_rd ? rd_word : 32'h0;
    end

endmodule

// File: rtl/irqd_checker.sv
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NL   = 64,
    parameter int NCPU = 1,
    localparam int IDW = $clog2(NL)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [9:0]     bus_addr,
    input logic [31:0]    bus_wdata,
    input logic [31:0]    bus_rdata,
    input logic           irq_valid,
    input logic [IDW-1:0] irq_id,
    input logic           ctrl_en,
    input logic [NL-1:0]  en_vec,
    input scan_state_e    scan_state
);

    localparam logic [31:0] EXP_TYPE = {24'b0, 3'(NCPU - 1), 5'(NL / 32 - 1)};
    localparam logic [9:0]  OOB_WORD = W_SETEN + 10'(NL / 32);

    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !irq_valid);

    a_r3_type_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == W_TYPE) |=> bus_rdata == EXP_TYPE);

    a_r4_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_SETEN) |=> (en_vec[31:0] & $past(bus_wdata)) == $past(bus_wdata));

    a_r4_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == W_CLREN) |=> (en_vec[31:0] & $past(bus_wdata)) == 32'h0);

    a_r4_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == W_SETEN || bus_addr == W_CLREN) && bus_wdata == 32'h0)
        |=> $stable(en_vec));

    a_r10_oob_read: assert property (@(posedge clk) disable iff (!rst_n)
        (NL / 32 < 32 && bus_rd && bus_addr == OOB_WORD) |=> bus_rdata == 32'h0);

    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_state == ST_SCAN) |=> $stable(irq_id));

endmodule

bind irqd_distributor irqd_checker #(.NL(NUM_LINES), .NCPU(NUM_CPUS)) u_irqd_checker (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_id(irq_id),
    .ctrl_en(ctrl_en), .en_vec(en_vec), .scan_state(scan_state)
);

// File: tb/test_irqd_distributor.sv
`timescale 1ns/1ps
module test_irqd_distributor;

    localparam int NL   = 64;
    localparam int WAIT = 2 * (NL + 1) + 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NL-1:0] irq_lines = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_valid;
    logic [5:0]  irq_id;
    logic [7:0]  irq_prio;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    irqd_distributor i_irqd_distributor (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_valid(irq_valid), .irq_id(irq_id), .irq_prio(irq_prio)
    );

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic settle();
        repeat (WAIT) @(negedge clk);
    endtask

    task automatic check_irq(input logic v, input logic [5:0] id, input logic [7:0] p,
                             input string tag);
        checks++;
        if (irq_valid !== v || (v && (irq_id !== id || irq_prio !== p))) begin
            errors++;
            $display("FAIL %s: valid=%0b id=%0d prio=%h expected valid=%0b id=%0d prio=%h",
                     tag, irq_valid, irq_id, irq_prio, v, id, p);
        end
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            if (bus_rd) begin
                @(negedge clk);
                if (exp_q.size() != 0) begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (bus_rdata !== e) begin
                        errors++;
                        $display("FAIL %s: rdata=%h expected %h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_irq(1'b0, 6'd0, 8'h00, "R1 reset no interrupt");
        rd(10'h000, 32'h0, "R1 control reset");
        rd(10'h040, 32'h0, "R1 enable reset");
        rd(10'h101, 32'h0, "R1 priority reset");
        rd(10'h001, 32'h1, "R3 type value");
        wr(10'h001, 32'hFFFF_FFFF);
        rd(10'h001, 32'h1, "R3 type write ignored");

        wr(10'h000, 32'h1);
        rd(10'h000, 32'h1, "R2 control readback");

        wr(10'h040, 32'h0000_00F0);
        rd(10'h040, 32'hF0, "R4 set-enable read");
        rd(10'h060, 32'hF0, "R4 clear window reads state");
        wr(10'h040, 32'h0);
        rd(10'h040, 32'hF0, "R4 zero write no effect");
        wr(10'h060, 32'h30);
        rd(10'h040, 32'hC0, "R4 clear-enable");
        wr(10'h041, 32'h1);
        rd(10'h041, 32'h1, "R4 second word");

        wr(10'h042, 32'hFFFF_FFFF);
        rd(10'h042, 32'h0, "R10 out-of-range word");
        rd(10'h040, 32'hC0, "R10 no aliasing");
        rd(10'h3FF, 32'h0, "R10 unmapped read");
        wr(10'h110, 32'h1234_5678);
        rd(10'h110, 32'h0, "R10 priority beyond lines");

        wr(10'h101, 32'h1020_3040);
        rd(10'h101, 32'h1020_3040, "R7 priority bytes");
        wr(10'h200, 32'h0102_0304);
        rd(10'h200, 32'h0102_0304, "R7 target bytes");

        wr(10'h300, 32'hFFFF_FFFF);
        rd(10'h300, 32'h0, "R8 low lines fixed");
        wr(10'h302, 32'hFFFF_FFFF);
        rd(10'h302, 32'hAAAA_AAAA, "R8 edge bits only");

        irq_lines[6] = 1'b1;
        rd(10'h080, 32'h40, "R9 level pending");
        settle();
        check_irq(1'b1, 6'd6, 8'h20, "R11 single line");
        irq_lines[7] = 1'b1;
        settle();
        check_irq(1'b1, 6'd7, 8'h10, "R11 lower priority value wins");
        wr(10'h0C0, 32'h80);
        rd(10'h0C0, 32'h80, "R6 set-active");
        rd(10'h0E0, 32'h80, "R6 clear window reads state");
        settle();
        check_irq(1'b1, 6'd6, 8'h20, "R11 active line excluded");
        wr(10'h0E0, 32'h80);
        rd(10'h0C0, 32'h0, "R6 clear-active");
        irq_lines[7:6] = 2'b00;
        rd(10'h080, 32'h0, "R9 level follows input");
        settle();
        check_irq(1'b0, 6'd0, 8'h00, "R11 nothing eligible");

        wr(10'h101, 32'h2020_3040);
        wr(10'h080, 32'hC0);
        rd(10'h0A0, 32'hC0, "R5 set-pending");
        settle();
        check_irq(1'b1, 6'd6, 8'h20, "R11 tie lowest line");
        wr(10'h000, 32'h0);
        check_irq(1'b0, 6'd0, 8'h00, "R2 global disable");
        wr(10'h000, 32'h1);
        settle();
        check_irq(1'b1, 6'd6, 8'h20, "R2 re-enable");
        wr(10'h080, 32'h0);
        rd(10'h080, 32'hC0, "R5 zero write no effect");
        wr(10'h0A0, 32'hC0);
        rd(10'h080, 32'h0, "R5 clear-pending");

        @(negedge clk); irq_lines[32] = 1'b1;
        @(negedge clk); irq_lines[32] = 1'b0;
        repeat (3) @(negedge clk);
        rd(10'h081, 32'h1, "R9 edge latched after fall");
        settle();
        check_irq(1'b1, 6'd32, 8'h00, "R11 edge line selected");
        wr(10'h0A1, 32'h1);
        rd(10'h081, 32'h0, "R5 clear edge pending");
        settle();
        check_irq(1'b0, 6'd0, 8'h00, "R12 refresh after clear");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule